// File: doc/BRIEF.md
# Multi-Mode PWM Channel Generator

This block produces one pulse-width-modulated waveform from a single channel counter. The counter advances on a tick picked from one of thirteen sources: the system clock divided by a power of two (2^0 up to 2^10) or one of two independent linear dividers whose ratio is set on an input. The channel either counts upward and wraps (edge-aligned) or counts up to the period value and back down to zero (center-aligned). Center-aligned mode doubles the period and places the active part of the waveform symmetrically around the peak, so that several channels can be set up with waveforms that never overlap.

Each period starts at a programmable resting level. The duty value gives the number of ticks per half-period (center mode) or per period (edge mode) spent at the opposite level, and these ticks sit at the end of the count-up. Period, duty, resting level and alignment are sampled only when a period ends, so changing them mid-period never shortens or splits a pulse. A one-cycle strobe marks the first clock of each period. All inputs are plain control levels; there is no streaming interface and no handshake.

Top module: `pwm_chan_gen`

## Requirements
- R1: During reset and until the first tick, `pwm_out` and `period_start` are 0. After reset the internal period is a single tick, so the first tick ends it: with `src_sel`=3, `period_start` is first 1 in the 8th clock after reset is released.
- R2: For `src_sel` values 0 to 10 the counter advances exactly once every 2^`src_sel` clock cycles, from a free-running prescaler that starts at zero on reset.
- R3: `src_sel`=11 selects divider A and `src_sel`=12 selects divider B; each gives one tick every `div_a_ratio` or `div_b_ratio` cycles. A ratio of 0, or `src_sel` 13 to 15, gives no ticks: the counter, `pwm_out` and `period_start` then hold still.
- R4: With `center_mode`=0 a period lasts P ticks; the output sits at the resting level for the first P−D ticks and at the opposite level for the last D ticks (P = period value, D = duty value).
- R5: With `center_mode`=1 a period lasts 2·P ticks: P−D ticks at the resting level, 2·D ticks at the opposite level centered on the count peak, then P−D ticks at the resting level.
- R6: D=0 keeps the output at the resting level for the whole period; D ≥ P keeps it at the opposite level for the whole period.
- R7: `pol_high`=0 makes the resting level low; `pol_high`=1 makes it high.
- R8: `prd_ticks`, `duty_ticks`, `pol_high` and `center_mode` are taken only at the tick that ends a period; changes at any other time leave the running period untouched.
- R9: `period_start` is 1 for exactly the first clock cycle of each period, and 0 in every other cycle of it.
- R10: A period value of 0 behaves as a period of 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 4 | Tick source: 0–10 prescaler tap, 11 divider A, 12 divider B, 13–15 none |
| div_a_ratio | input | DIV_W | Divider A ratio in clock cycles (0 stops it) |
| div_b_ratio | input | DIV_W | Divider B ratio in clock cycles (0 stops it) |
| prd_ticks | input | CNT_W | Period value P in ticks |
| duty_ticks | input | CNT_W | Duty value D: opposite-level ticks per half/whole period |
| pol_high | input | 1 | Resting level at the start of each period (1 = high) |
| center_mode | input | 1 | 1 = up/down counting, 0 = up counting with wrap |
| pwm_out | output | 1 | Waveform output |
| period_start | output | 1 | One-cycle strobe in the first clock of each period |

## Verification
The bench walks every combination of a small period range (including 0), a duty range that runs past the period, both levels and both alignments, and checks the output and strobe in every clock of every period against an arithmetic model; a design that mixed up the edge at the count peak would show a center pulse one tick short or long, and one that mishandled D ≥ P would leave a one-tick resting glitch. The next configuration is always applied in the first cycle of the current period, so a design that took settings live instead of at the boundary would change the waveform mid-period. Tick spacing is checked across prescaler taps, both linear dividers and a ratio of 1, so an off-by-one divider would stretch every period by a whole tick per count. Finally, a zero ratio and unused source codes are selected mid-period to catch a design whose counter or output keeps moving with no tick.

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
package pwm_chan_pkg;
  // Number of power-of-two prescaler taps (divide by 2^0 .. 2^10)
  localparam int unsigned PRE_TAPS = 11;
  // Width of the tick source select
  localparam int unsigned SRC_W = 4;
  // Source codes of the two linear dividers (follow the prescaler taps)
  localparam logic [SRC_W-1:0] SRC_DIV_A = SRC_W'(PRE_TAPS);
  localparam logic [SRC_W-1:0] SRC_DIV_B = SRC_W'(PRE_TAPS + 1);

  typedef enum logic {CNT_UP = 1'b0, CNT_DOWN = 1'b1} cnt_dir_e;
endpackage

// File: rtl/pwm_lin_div.sv
`timescale 1ns/1ps
// Linear clock divider: one tick every `ratio` cycles, none when ratio is 0.
module pwm_lin_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             hit;

  assign hit  = (ratio != '0) && (cnt_q >= ratio - DIV_W'(1));
  assign tick = hit;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (ratio == '0)   cnt_q <= '0;
    else if (hit)           cnt_q <= '0;
    else                    cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/pwm_tick_sel.sv
`timescale 1ns/1ps
// Tick source selection: power-of-two prescaler taps and two linear dividers.
module pwm_tick_sel
  import pwm_chan_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [DIV_W-1:0] div_a_ratio,
  input  logic [DIV_W-1:0] div_b_ratio,
  output logic             tick
);
  localparam int unsigned PRE_W  = PRE_TAPS - 1;
  localparam int unsigned SEL_N  = 1 << SRC_W;
  localparam int unsigned N_DIV  = 2;
  localparam int unsigned PAD    = SEL_N - PRE_TAPS - N_DIV;

  logic [PRE_W-1:0]    pre_q;
  logic [PRE_TAPS-1:0] tap_hit;
  logic [N_DIV-1:0]    div_tick;
  logic [DIV_W-1:0]    ratio [N_DIV];
  logic [SEL_N-1:0]    src_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  // Tap g fires once every 2^g cycles
  for (genvar g = 0; g < PRE_TAPS; g++) begin : g_tap
    if (g == 0) begin : g_every
      assign tap_hit[g] = 1'b1;
    end else begin : g_div
      assign tap_hit[g] = &pre_q[g-1:0];
    end
  end

  assign ratio[0] = div_a_ratio;
  assign ratio[1] = div_b_ratio;

  for (genvar d = 0; d < N_DIV; d++) begin : g_lin
    pwm_lin_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .ratio (ratio[d]),
      .tick  (div_tick[d])
    );
  end

  // Unused codes read constant zero: no tick
  assign src_vec = {{PAD{1'b0}}, div_tick, tap_hit};
  assign tick    = src_vec[src_sel];
endmodule

// File: rtl/pwm_chan_core.sv
`timescale 1ns/1ps
// Channel counter, boundary-buffered settings and compare logic.
module pwm_chan_core
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cfg_prd,
  input  logic [CNT_W-1:0] cfg_dty,
  input  logic             cfg_pol,
  input  logic             cfg_ctr,
  output logic             pwm_out,
  output logic             period_start,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic [CNT_W-1:0] act_prd_o,
  output logic [CNT_W-1:0] act_dty_o,
  output logic             act_pol_o,
  output logic             act_ctr_o
);
  typedef struct packed {
    logic [CNT_W-1:0] prd;
    logic [CNT_W-1:0] dty;
    logic             pol;
    logic             ctr;
  } chan_cfg_t;

  chan_cfg_t        act_q, nxt_cfg;
  logic [CNT_W-1:0] cnt_q, cnt_d, thr;
  cnt_dir_e         dir_q, dir_d;
  logic             wrap, opp, pstart_q;

  // Settings presented for the next period; zero period acts as one tick
  always_comb begin
    nxt_cfg.prd = (cfg_prd == '0) ? CNT_W'(1) : cfg_prd;
    nxt_cfg.dty = cfg_dty;
    nxt_cfg.pol = cfg_pol;
    nxt_cfg.ctr = cfg_ctr;
  end

  // Next count on a tick
  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (!act_q.ctr) begin
      if (cnt_q + CNT_W'(1) >= act_q.prd) begin
        wrap  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (dir_q == CNT_UP) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q + CNT_W'(1) == act_q.prd) dir_d = CNT_DOWN;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        wrap  = 1'b1;
        dir_d = CNT_UP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      dir_q     <= CNT_UP;
      act_q.prd <= CNT_W'(1);
      act_q.dty <= '0;
      act_q.pol <= 1'b0;
      act_q.ctr <= 1'b0;
      pstart_q  <= 1'b0;
    end else begin
      pstart_q <= tick && wrap;
      if (tick) begin
        cnt_q <= cnt_d;
        dir_q <= dir_d;
        if (wrap) act_q <= nxt_cfg;
      end
    end
  end

  // Opposite level from threshold P-D (saturating at 0 when D >= P)
  assign thr = (act_q.dty >= act_q.prd) ? '0 : act_q.prd - act_q.dty;
  assign opp = (dir_q == CNT_UP) ? (cnt_q >= thr) : (cnt_q > thr);

  assign pwm_out      = act_q.pol ^ opp;
  assign period_start = pstart_q;
  assign cnt_o        = cnt_q;
  assign dir_o        = (dir_q == CNT_DOWN);
  assign act_prd_o    = act_q.prd;
  assign act_dty_o    = act_q.dty;
  assign act_pol_o    = act_q.pol;
  assign act_ctr_o    = act_q.ctr;
endmodule

// File: rtl/pwm_chan_gen.sv
`timescale 1ns/1ps
// Top: tick selection feeding one PWM channel.
module pwm_chan_gen
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [DIV_W-1:0] div_a_ratio,
  input  logic [DIV_W-1:0] div_b_ratio,
  input  logic [CNT_W-1:0] prd_ticks,
  input  logic [CNT_W-1:0] duty_ticks,
  input  logic             pol_high,
  input  logic             center_mode,
  output logic             pwm_out,
  output logic             period_start
);
  logic             tick;
  logic [CNT_W-1:0] cnt_w, act_prd_w, act_dty_w;
  logic             dir_w, act_pol_w, act_ctr_w;

  pwm_tick_sel #(.DIV_W(DIV_W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .div_a_ratio (div_a_ratio),
    .div_b_ratio (div_b_ratio),
    .tick        (tick)
  );

  pwm_chan_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .cfg_prd      (prd_ticks),
    .cfg_dty      (duty_ticks),
    .cfg_pol      (pol_high),
    .cfg_ctr      (center_mode),
    .pwm_out      (pwm_out),
    .period_start (period_start),
    .cnt_o        (cnt_w),
    .dir_o        (dir_w),
    .act_prd_o    (act_prd_w),
    .act_dty_o    (act_dty_w),
    .act_pol_o    (act_pol_w),
    .act_ctr_o    (act_ctr_w)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
`timescale 1ns/1ps
// Property checker, bound to the top module.
module pwm_chan_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             dir,
  input logic [CNT_W-1:0] act_prd,
  input logic [CNT_W-1:0] act_dty,
  input logic             act_pol,
  input logic             act_ctr,
  input logic             pwm_out,
  input logic             period_start
);
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n) !period_start |-> ($stable(act_prd) && $stable(act_dty) && $stable(act_pol) && $stable(act_ctr))); // R8
  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) !act_ctr |-> (cnt < act_prd && !dir)); // R4
  AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n) act_ctr |-> (cnt <= act_prd)); // R5
  AST_PEAK_TURN: assert property (@(posedge clk) disable iff (!rst_n) $rose(dir) |-> (cnt == act_prd)); // R5
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> ($stable(cnt) && $stable(dir) && !period_start)); // R3
  AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) period_start |-> (cnt == '0 && !dir)); // R9
  AST_ZERO_DUTY_REST: assert property (@(posedge clk) disable iff (!rst_n) (act_dty == '0) |-> (pwm_out == act_pol)); // R6
  AST_FULL_DUTY_OPP: assert property (@(posedge clk) disable iff (!rst_n) (act_dty >= act_prd) |-> (pwm_out != act_pol)); // R6
  AST_PRD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) act_prd != '0); // R10
endmodule

bind pwm_chan_gen pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .cnt          (cnt_w),
  .dir          (dir_w),
  .act_prd      (act_prd_w),
  .act_dty      (act_dty_w),
  .act_pol      (act_pol_w),
  .act_ctr      (act_ctr_w),
  .pwm_out      (pwm_out),
  .period_start (period_start)
);

// File: tb/sim_pwm_chan_gen.sv
`timescale 1ns/1ps
module sim_pwm_chan_gen;
  import pwm_chan_pkg::*;

  localparam int CW = 16;
  localparam int DW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [SRC_W-1:0] src;
  logic [DW-1:0]  da, db;
  logic [CW-1:0]  prd, dty;
  logic           pol, ctr;
  wire            pwm, pst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int cfg_p[256], cfg_d[256], cfg_l[256], cfg_c[256];
  int n_cfg = 0;

  always #2.5 clk = ~clk;

  pwm_chan_gen #(.CNT_W(CW), .DIV_W(DW)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_sel      (src),
    .div_a_ratio  (da),
    .div_b_ratio  (db),
    .prd_ticks    (prd),
    .duty_ticks   (dty),
    .pol_high     (pol),
    .center_mode  (ctr),
    .pwm_out      (pwm),
    .period_start (pst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic add(input int p, input int d, input int l, input int c);
    cfg_p[n_cfg] = p; cfg_d[n_cfg] = d; cfg_l[n_cfg] = l; cfg_c[n_cfg] = c;
    n_cfg++;
  endtask

  task automatic apply(input int i);
    prd = CW'(cfg_p[i]);
    dty = CW'(cfg_d[i]);
    pol = cfg_l[i][0];
    ctr = cfg_c[i][0];
  endtask

  task automatic sync_boundary();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pst && n < 5000);
    check(pst === 1'b1, "R9 boundary strobe seen", int'(pst), 1);
  endtask

  // Entered at the sample where period_start is 1 for config i.
  task automatic check_period(input int T, input string stag, input int i, input int nx);
    int p, d, pe, thr, len, t, v, e;
    string tag;
    bit opp;
    p = cfg_p[i]; d = cfg_d[i];
    pe = (p == 0) ? 1 : p;
    thr = (d >= pe) ? 0 : pe - d;
    len = (cfg_c[i] != 0 ? 2 : 1) * pe * T;
    tag = (cfg_c[i] != 0) ? "R5" : "R4";
    if (p == 0) tag = {tag, " R10"};
    if (d == 0 || d >= pe) tag = {tag, " R6"};
    if (cfg_l[i] != 0) tag = {tag, " R7"};
    if (cfg_p[nx] != p || cfg_d[nx] != d || cfg_l[nx] != cfg_l[i] || cfg_c[nx] != cfg_c[i])
      tag = {tag, " R8"};
    tag = {tag, " ", stag};
    apply(nx);  // next settings arrive at once; must wait for the boundary
    for (int j = 0; j <= len; j++) begin
      if (j > 0) @(negedge clk);
      if (j == len) begin
        check(pst === 1'b1, $sformatf("R9 strobe at period end P=%0d D=%0d c=%0d", p, d, cfg_c[i]), int'(pst), 1);
      end else begin
        if (j > 0)
          check(pst === 1'b0, $sformatf("R9 no strobe mid-period j=%0d", j), int'(pst), 0);
        t = j / T;
        if (cfg_c[i] == 0) opp = (t >= thr);
        else if (t < pe) opp = (t >= thr);
        else begin
          v = 2 * pe - t;
          opp = (v > thr);
        end
        e = cfg_l[i] ^ int'(opp);
        check(pwm === e[0], $sformatf("%s out P=%0d D=%0d pol=%0d c=%0d j=%0d", tag, p, d, cfg_l[i], cfg_c[i], j),
              int'(pwm), e);
      end
    end
  endtask

  task automatic run_group(input logic [SRC_W-1:0] s, input int T, input string stag);
    apply(0);
    src = s;
    sync_boundary();
    for (int i = 0; i < n_cfg; i++)
      check_period(T, stag, i, (i + 1 < n_cfg) ? i + 1 : i);
  endtask

  task automatic frozen(input string why);
    logic o;
    repeat (3) @(negedge clk);
    o = pwm;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check(pst === 1'b0, {"R3 no strobe without tick: ", why}, int'(pst), 0);
      check(pwm === o, {"R3 output held without tick: ", why}, int'(pwm), int'(o));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    src = 4'd3; da = 8'd3; db = 8'd5;
    prd = 16'd2; dty = 16'd1; pol = 1'b1; ctr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pwm === 1'b0, "R1 output low in reset", int'(pwm), 0);
    check(pst === 1'b0, "R1 strobe low in reset", int'(pst), 0);
    rst_n = 1'b1;
    // First tick of tap 3 lands after 8 cycles and ends the one-tick reset period
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k < 8) begin
        check(pst === 1'b0, $sformatf("R1 R2 no strobe before first tick k=%0d", k), int'(pst), 0);
        check(pwm === 1'b0, $sformatf("R1 output low before first tick k=%0d", k), int'(pwm), 0);
      end else begin
        check(pst === 1'b1, "R1 R2 strobe after first tick", int'(pst), 1);
      end
    end

    // Full sweep at one tick per clock
    n_cfg = 0;
    for (int p = 0; p <= 5; p++)
      for (int d = 0; d <= 6; d++)
        for (int l = 0; l < 2; l++)
          for (int c = 0; c < 2; c++)
            add(p, d, l, c);
    run_group(4'd0, 1, "R2");

    n_cfg = 0;
    foreach (cfg_p[k]) if (k < 0) break;
    for (int pi = 0; pi < 2; pi++)
      for (int d = 0; d <= 3; d++)
        if (d != 2)
          for (int l = 0; l < 2; l++)
            for (int c = 0; c < 2; c++)
              add(pi == 0 ? 1 : 3, d, l, c);
    run_group(4'd2, 4, "R2");

    n_cfg = 0;
    for (int d = 1; d <= 2; d++)
      for (int l = 0; l < 2; l++)
        for (int c = 0; c < 2; c++)
          add(2, d, l, c);
    run_group(4'd3, 8, "R2");

    n_cfg = 0;
    add(1, 0, 1, 0);
    add(2, 1, 0, 0);
    run_group(4'd10, 1024, "R2");

    n_cfg = 0;
    for (int p = 2; p <= 3; p++)
      for (int d = 0; d <= 3; d++)
        for (int l = 0; l < 2; l++)
          for (int c = 0; c < 2; c++)
            add(p, d, l, c);
    da = 8'd3;
    run_group(SRC_DIV_A, 3, "R3");

    n_cfg = 0;
    for (int d = 1; d <= 2; d++)
      for (int l = 0; l < 2; l++)
        for (int c = 0; c < 2; c++)
          add(2, d, l, c);
    db = 8'd5;
    run_group(SRC_DIV_B, 5, "R3");

    da = 8'd1;
    run_group(SRC_DIV_A, 1, "R3");

    // No tick: zero ratio, then an unused source code
    n_cfg = 0;
    add(4, 2, 0, 1);
    apply(0);
    src = 4'd0;
    sync_boundary();
    repeat (3) @(negedge clk);
    da = 8'd0;
    src = SRC_DIV_A;
    frozen("ratio zero");
    da = 8'd2;
    repeat (2) @(negedge clk);
    src = 4'd14;
    frozen("unused source code");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule